// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block decides, every cycle, where the two ALU operands of a five-stage in-order integer pipeline come from, and whether the front of the pipeline must pause. It compares the source registers of the instruction in the execute stage with the destinations held in the two later pipeline registers. From that comparison it picks, for each operand, either the value read from the register file or a result that has not yet been written back. A result that is only two stages downstream arrives through the late bypass. A result three stages downstream reaches the consumer because the register file returns a value written in the same cycle, with the write taking effect before the read.

A load cannot be bypassed into the instruction right after it. For that case the block looks at the instruction just fetched, now in decode, and compares it with a load in the execute stage. When the load's destination is one of its sources, the block raises a stall that holds the PC and the fetch/decode register. In the same cycle it raises a bubble that turns the next execute-stage entry into a no-op. This costs exactly one cycle. The block has no state of its own: its outputs are a pure function of the pipeline register fields it is given. The clock and reset feed only its embedded checks.

Top module: `hz_bypass_ctrl`

## Requirements
- R1: When the EX/MEM stage writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (take the EX/MEM result).
- R2: When only the MEM/WB stage writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (take the MEM/WB result).
- R3: When both EX/MEM and MEM/WB write the same matching register, the select is 2'b10; the younger result wins.
- R4: Register 0 is never forwarded and never causes a stall, whatever the write enables say.
- R5: A stage whose write enable is low takes no part in forwarding or in the load-use check.
- R6: With no match, including after reset with every write enable low, both selects are 2'b00 (register file) and stall and bubble are low.
- R7: Stall is high exactly when the execute-stage entry is a load with its write enable high and a nonzero destination equal to either decode-stage source.
- R8: Bubble equals stall. A single load-use pair stalls for exactly one cycle, and stall is never high in two consecutive cycles in a pipeline that obeys the bubble.
- R9: In a pipeline that steers its ALU inputs with these selects, stalls on the stall output, and uses a write-before-read register file, every ALU operand equals the value that strictly sequential execution would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| idex_rs1 | input | REG_W | First source register of the execute-stage instruction |
| idex_rs2 | input | REG_W | Second source register of the execute-stage instruction |
| idex_rd | input | REG_W | Destination register of the execute-stage instruction |
| idex_we | input | 1 | Execute-stage instruction writes a register |
| idex_load | input | 1 | Execute-stage instruction is a load |
| exmem_rd | input | REG_W | Destination register in EX/MEM |
| exmem_we | input | 1 | EX/MEM entry writes a register |
| memwb_rd | input | REG_W | Destination register in MEM/WB |
| memwb_we | input | 1 | MEM/WB entry writes a register |
| ifid_rs1 | input | REG_W | First source register of the decode-stage instruction |
| ifid_rs2 | input | REG_W | Second source register of the decode-stage instruction |
| fwd_a | output | 2 | Select for ALU operand A: 00 register file, 01 MEM/WB, 10 EX/MEM |
| fwd_b | output | 2 | Select for ALU operand B, same encoding |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the execute stage instead of the decoded entry |

## Verification
The bench goes after the cases where both later stages hold the same destination. A design with the priority reversed would feed the consumer a stale, older result. It also drives register 0 with its write enable high and expects no bypass; a design that forwards it would corrupt the hard-wired zero. It drives a matching destination with its write enable low, which must be ignored. It drives a load followed at once by a consumer, where a missing stall lets the consumer read the value before the load has produced it, and a non-load producer in the same position, where a spurious stall only costs time. A randomized instruction stream runs through a behavioural pipeline with a write-through register file. Every ALU operand is compared with a sequential model, so a wrong select or a missed interlock shows up as a wrong operand value.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] em_rd,
  input  logic             em_we,
  input  logic [REG_W-1:0] mw_rd,
  input  logic             mw_we,
  output fwd_sel_e         sel
);
  logic em_hit;
  logic mw_hit;

  // register 0 is hard-wired and never a dependence
  assign em_hit = em_we && (em_rd != '0) && (em_rd == src);
  assign mw_hit = mw_we && (mw_rd != '0) && (mw_rd == src);

  // younger result (EX/MEM) checked first
  always_comb begin
    sel = FWD_RF;
    if (em_hit)      sel = FWD_EXMEM;
    else if (mw_hit) sel = FWD_MEMWB;
  end
endmodule

// File: rtl/hz_ldu_detect.sv
module hz_ldu_detect #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_ld,
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  output logic             hazard
);
  logic producer_ok;
  logic use_hit;

  assign producer_ok = ex_ld && ex_we && (ex_rd != '0);
  assign use_hit     = (ex_rd == dec_rs1) || (ex_rd == dec_rs2);
  assign hazard      = producer_ok && use_hit;
endmodule

// File: rtl/hz_bypass_ctrl.sv
module hz_bypass_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] idex_rs1,
  input  logic [REG_W-1:0] idex_rs2,
  input  logic [REG_W-1:0] idex_rd,
  input  logic             idex_we,
  input  logic             idex_load,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic [REG_W-1:0] memwb_rd,
  input  logic             memwb_we,
  input  logic [REG_W-1:0] ifid_rs1,
  input  logic [REG_W-1:0] ifid_rs2,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] srcs [NSRC];
  fwd_sel_e         sels [NSRC];
  logic             ldu;

  assign srcs[0] = idex_rs1;
  assign srcs[1] = idex_rs2;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_operand
      hz_fwd_select #(.REG_W(REG_W)) u_sel (
        .src   (srcs[g]),
        .em_rd (exmem_rd),
        .em_we (exmem_we),
        .mw_rd (memwb_rd),
        .mw_we (memwb_we),
        .sel   (sels[g])
      );
    end
  endgenerate

  hz_ldu_detect #(.REG_W(REG_W)) u_ldu (
    .ex_rd   (idex_rd),
    .ex_we   (idex_we),
    .ex_ld   (idex_load),
    .dec_rs1 (ifid_rs1),
    .dec_rs2 (ifid_rs2),
    .hazard  (ldu)
  );

  assign fwd_a  = 2'(sels[0]);
  assign fwd_b  = 2'(sels[1]);
  assign stall  = ldu;
  assign bubble = ldu;

  AST_EXMEM_WINS: assert property (@(posedge clk) disable iff (rst)
    (exmem_we && exmem_rd != '0 && exmem_rd == idex_rs1) |-> fwd_a == 2'b10); // R3
  AST_MEMWB_ONLY: assert property (@(posedge clk) disable iff (rst)
    (memwb_we && memwb_rd != '0 && memwb_rd == idex_rs2 &&
     !(exmem_we && exmem_rd == idex_rs2)) |-> fwd_b == 2'b01); // R2
  AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
    (idex_rs1 == '0) |-> fwd_a == 2'b00); // R4
  AST_WE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!exmem_we && !memwb_we) |-> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R5
  AST_STALL_LOAD: assert property (@(posedge clk) disable iff (rst)
    stall |-> (idex_load && idex_we && idex_rd != '0)); // R7
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R8
endmodule

// File: tb/hz_bypass_ctrl_bench.sv
`timescale 1ns/1ps
module hz_bypass_ctrl_bench;
  localparam int REG_W = 5;
  localparam int N     = 400;

  typedef struct packed {
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [4:0]  rd;
    logic        we;
    logic        ld;
    logic        v;
    int          id;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] val;
  } stg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  stg_t fd, ie, em, mw;
  stg_t prog [N];
  logic [31:0] a_exp [N];
  logic [31:0] b_exp [N];
  logic [31:0] rf  [32];
  logic [31:0] rfr [32];

  logic [1:0] fwd_a, fwd_b;
  logic       stall, bubble;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hz_bypass_ctrl #(.REG_W(REG_W)) u_hz_bypass_ctrl (
    .clk(clk), .rst(rst),
    .idex_rs1(ie.rs1), .idex_rs2(ie.rs2), .idex_rd(ie.rd),
    .idex_we(ie.we), .idex_load(ie.ld),
    .exmem_rd(em.rd), .exmem_we(em.we),
    .memwb_rd(mw.rd), .memwb_we(mw.we),
    .ifid_rs1(fd.rs1), .ifid_rs2(fd.rs2),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble)
  );

  function automatic logic [31:0] ldval(int i);
    return 32'hA500_0000 ^ (i * 32'h0000_9E37);
  endfunction

  function automatic logic [31:0] aluf(logic [31:0] a, logic [31:0] b, int i);
    return a + (b << 1) + i;
  endfunction

  function automatic logic [1:0] exp_sel(logic [4:0] rs, stg_t e, stg_t w);
    if (e.we && e.rd != 0 && e.rd == rs) return 2'b10;
    if (w.we && w.rd != 0 && w.rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic dcase(string req,
                       logic [4:0] f1, logic [4:0] f2, logic [4:0] s1, logic [4:0] s2,
                       logic [4:0] erd, bit ewe, bit eld,
                       logic [4:0] xrd, bit xwe, logic [4:0] wrd, bit wwe,
                       logic [1:0] ea, logic [1:0] eb, bit es);
    fd = '0; ie = '0; em = '0; mw = '0;
    fd.rs1 = f1; fd.rs2 = f2;
    ie.rs1 = s1; ie.rs2 = s2; ie.rd = erd; ie.we = ewe; ie.ld = eld;
    em.rd = xrd; em.we = xwe;
    mw.rd = wrd; mw.we = wwe;
    #1;
    chk(req, "fwd_a", 32'(fwd_a), 32'(ea));
    chk(req, "fwd_b", 32'(fwd_b), 32'(eb));
    chk(req, "stall", 32'(stall), 32'(es));
    chk(req, "bubble", 32'(bubble), 32'(es));
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int pc, retired;
    logic [31:0] opa, opb, res;
    stg_t nie, nem, nmw, nfd;

    seed = $urandom(20240611);
    fd = '0; ie = '0; em = '0; mw = '0;

    // build program and sequential reference
    for (int r = 0; r < 32; r++) begin rf[r] = 32'h0; rfr[r] = 32'h0; end
    for (int i = 0; i < N; i++) begin
      prog[i]     = '0;
      prog[i].rs1 = 5'($urandom_range(0, 7));
      prog[i].rs2 = 5'($urandom_range(0, 7));
      prog[i].rd  = 5'($urandom_range(0, 7));
      prog[i].we  = ($urandom_range(0, 7) != 0);
      prog[i].ld  = ($urandom_range(0, 2) == 0);
      prog[i].v   = 1'b1;
      prog[i].id  = i;
      a_exp[i] = rfr[prog[i].rs1];
      b_exp[i] = rfr[prog[i].rs2];
      res = prog[i].ld ? ldval(i) : aluf(a_exp[i], b_exp[i], i);
      if (prog[i].we && prog[i].rd != 0) rfr[prog[i].rd] = res;
    end

    // reset state, R6
    repeat (3) @(negedge clk);
    #1;
    chk("R6", "reset fwd_a", 32'(fwd_a), 0);
    chk("R6", "reset fwd_b", 32'(fwd_b), 0);
    chk("R6", "reset stall", 32'(stall), 0);
    @(posedge clk); rst = 1'b0;
    @(negedge clk);

    // directed corner cases
    dcase("R1", 0, 0, 3, 1, 0, 0, 0, 3, 1, 0, 0, 2'b10, 2'b00, 0);
    dcase("R2", 0, 0, 1, 4, 0, 0, 0, 0, 0, 4, 1, 2'b00, 2'b01, 0);
    dcase("R3", 0, 0, 5, 5, 0, 0, 0, 5, 1, 5, 1, 2'b10, 2'b10, 0);
    dcase("R3", 0, 0, 6, 2, 0, 0, 0, 2, 1, 6, 1, 2'b01, 2'b10, 0);
    dcase("R4", 0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1, 2'b00, 2'b00, 0);
    dcase("R5", 0, 0, 6, 6, 0, 0, 0, 6, 0, 6, 0, 2'b00, 2'b00, 0);
    dcase("R5", 7, 0, 0, 0, 7, 0, 1, 0, 0, 0, 0, 2'b00, 2'b00, 0);
    dcase("R7", 0, 7, 0, 0, 7, 1, 1, 0, 0, 0, 0, 2'b00, 2'b00, 1);
    dcase("R6", 0, 0, 2, 3, 0, 0, 0, 4, 1, 5, 1, 2'b00, 2'b00, 0);
    dcase("R7", 7, 0, 0, 0, 7, 1, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0);
    dcase("R8", 9, 1, 0, 0, 9, 1, 1, 0, 0, 0, 0, 2'b00, 2'b00, 1);
    dcase("R7", 3, 4, 0, 0, 9, 1, 1, 0, 0, 0, 0, 2'b00, 2'b00, 0);

    // random stream through a behavioural pipeline
    fd = '0; ie = '0; em = '0; mw = '0;
    pc = 0; retired = 0;
    while (retired < N) begin
      #1;
      chk("R1/R2/R3", "fwd_a", 32'(fwd_a), 32'(exp_sel(ie.rs1, em, mw)));
      chk("R1/R2/R3", "fwd_b", 32'(fwd_b), 32'(exp_sel(ie.rs2, em, mw)));
      chk("R7", "stall", 32'(stall),
          32'(ie.ld && ie.we && ie.rd != 0 && (ie.rd == fd.rs1 || ie.rd == fd.rs2)));
      chk("R8", "bubble", 32'(bubble), 32'(stall));
      opa = (fwd_a == 2'b10) ? em.val : (fwd_a == 2'b01) ? mw.val : ie.a;
      opb = (fwd_b == 2'b10) ? em.val : (fwd_b == 2'b01) ? mw.val : ie.b;
      if (ie.v) begin
        chk("R9", $sformatf("operand A of #%0d", ie.id), opa, a_exp[ie.id]);
        chk("R9", $sformatf("operand B of #%0d", ie.id), opb, b_exp[ie.id]);
      end
      // write-back happens before the decode read
      if (mw.v) begin
        if (mw.we && mw.rd != 0) rf[mw.rd] = mw.val;
        retired++;
      end
      nmw = em;
      nem = ie;
      if (ie.v) nem.val = ie.ld ? ldval(ie.id) : aluf(opa, opb, ie.id);
      if (stall) begin
        nie = '0;
        nfd = fd;
      end else begin
        nie   = fd;
        nie.a = rf[fd.rs1];
        nie.b = rf[fd.rs2];
        if (!fd.v) nie = '0;
        if (pc < N) begin nfd = prog[pc]; pc++; end
        else nfd = '0;
      end
      mw = nmw; em = nem; ie = nie; fd = nfd;
      @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule